// File: doc/BRIEF.md
# Multi-Owner Hardware Lock Register Bank

This block holds one ownership bitmap per software agent and lets the agents take and give back exclusive use of a set of shared resources. Bit r of agent a's bitmap is 1 exactly when agent a holds resource r. Each agent has its own write port with an operation select that stands for the two write aliases of its register. Offset 1 (operation 1) is the claim alias and offset 0 (operation 0) is the release alias. Each agent also has a read port that returns its bitmap.

A claim is granted bit by bit. A requested resource goes to the requester only if no agent holds it in the cycle of the request. When several agents ask for the same free resource in one cycle, the lowest-numbered agent gets it. Misuse sets a sticky error status bit. Misuse means claiming a resource the agent already holds, or releasing one it does not hold. The error status drives an interrupt line through an enable.

Top module: `hwlock_bank`

## Requirements
- R1: After a synchronous reset every ownership bitmap, every read data word, the error status and the interrupt are 0.
- R2: A write with operation 1 (claim) sets bit r of the writer's bitmap on the next clock edge when bit r of the data is 1 and no agent held resource r before that edge.
- R3: A claimed bit stays 0 when another agent held the resource before the edge, even if that holder releases it in the same cycle.
- R4: When several agents claim the same free resource in one cycle, only the lowest-numbered of them is granted it.
- R5: A write with operation 0 (release) clears, on the next edge, every bit of the writer's bitmap whose data bit is 1.
- R6: Data bits that are 0 leave the matching ownership bits unchanged, for claims and releases alike, and agents that do not write keep their bitmaps.
- R7: Claiming a resource the writer already holds sets the error status on the next edge and leaves that ownership bit at 1.
- R8: Releasing a resource the writer does not hold sets the error status on the next edge.
- R9: The error status stays 1 until a cycle with irq_clr high clears it. A new misuse in that same cycle keeps it at 1.
- R10: irq is registered and equals, after each edge, the new error status ANDed with irq_en sampled at that edge.
- R11: A read presented with rd_en returns, one cycle later, the agent's bitmap as it stood in the cycle the read was presented.
- R12: At no time does any resource have more than one owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| agt_wr_en | input | NUM_AGENTS | Per-agent write strobe |
| agt_wr_op | input | NUM_AGENTS | Per-agent alias select: 1 claim, 0 release |
| agt_wr_data | input | NUM_AGENTS*NUM_RES | Per-agent write data, agent a in bits [a*NUM_RES +: NUM_RES] |
| agt_rd_en | input | NUM_AGENTS | Per-agent read strobe |
| agt_rd_data | output | NUM_AGENTS*NUM_RES | Per-agent registered read data, same packing as the write data |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-1-to-clear strobe for the error status |
| irq_sts | output | 1 | Sticky error status |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check several properties. No resource ever has two owners. An ownership bit rises only when the agent claimed it and no agent held it. A bit falls only when its holder released it. Misuse is always followed by a set status, the status is sticky, and the interrupt respects its enable. Only the bench scenarios can show that the lowest-numbered contender is the one that wins and that a release and a claim in the same cycle deny the claim. They also show that reads return the pre-write bitmap, and that a long mixed sweep of claims, releases and clears matches an arithmetic model bit for bit.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  // Alias select on an agent's write port (address offset of the alias)
  typedef enum logic {
    LOCK_OP_RELEASE = 1'b0,
    LOCK_OP_CLAIM   = 1'b1
  } lock_op_e;

  localparam int DEF_AGENTS = 16;
  localparam int DEF_RES    = 32;
endpackage

// File: rtl/hwlock_arb_col.sv
// Per-resource arbiter: grants a free resource to the lowest requester.
module hwlock_arb_col #(
  parameter int NUM_AGENTS = 16
) (
  input  logic [NUM_AGENTS-1:0] req,
  input  logic [NUM_AGENTS-1:0] holders,
  output logic [NUM_AGENTS-1:0] grant
);
  logic [NUM_AGENTS-1:0] lowest;

  // isolate lowest set bit of the request vector
  assign lowest = req & (~req + {{(NUM_AGENTS-1){1'b0}}, 1'b1});

  always_comb begin
    grant = '0;
    if (holders == '0) grant = lowest;
  end
endmodule

// File: rtl/hwlock_agent_reg.sv
// One agent's ownership register with its claim/release aliases and read port.
module hwlock_agent_reg
  import hwlock_pkg::*;
#(
  parameter int NUM_RES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_op,
  input  logic [NUM_RES-1:0] wr_data,
  input  logic [NUM_RES-1:0] grant,
  input  logic               rd_en,
  output logic [NUM_RES-1:0] own,
  output logic [NUM_RES-1:0] rd_data,
  output logic               misuse
);
  logic is_claim;

  assign is_claim = (wr_op == LOCK_OP_CLAIM);

  always_comb begin
    misuse = 1'b0;
    if (wr_en) begin
      if (is_claim) misuse = |(wr_data & own);
      else          misuse = |(wr_data & ~own);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own     <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        if (is_claim) own <= own | grant;
        else          own <= own & ~wr_data;
      end
      if (rd_en) rd_data <= own;
    end
  end
endmodule

// File: rtl/hwlock_err_stat.sv
// Sticky misuse status with write-1-to-clear and a registered gated interrupt.
module hwlock_err_stat (
  input  logic clk,
  input  logic rst,
  input  logic misuse_any,
  input  logic clr,
  input  logic en,
  output logic sts,
  output logic irq
);
  logic sts_d;

  // a new misuse wins over a clear in the same cycle
  assign sts_d = misuse_any | (sts & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= 1'b0;
      irq <= 1'b0;
    end else begin
      sts <= sts_d;
      irq <= sts_d & en;
    end
  end
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int NUM_AGENTS = DEF_AGENTS,
  parameter int NUM_RES    = DEF_RES
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_AGENTS-1:0]         agt_wr_en,
  input  logic [NUM_AGENTS-1:0]         agt_wr_op,
  input  logic [NUM_AGENTS*NUM_RES-1:0] agt_wr_data,
  input  logic [NUM_AGENTS-1:0]         agt_rd_en,
  output logic [NUM_AGENTS*NUM_RES-1:0] agt_rd_data,
  input  logic                          irq_en,
  input  logic                          irq_clr,
  output logic                          irq_sts,
  output logic                          irq
);
  localparam int FLAT_W = NUM_AGENTS * NUM_RES;

  logic [NUM_RES-1:0]    claim_row [NUM_AGENTS];
  logic [NUM_RES-1:0]    own_row   [NUM_AGENTS];
  logic [NUM_RES-1:0]    grant_row [NUM_AGENTS];
  logic [NUM_RES-1:0]    rd_row    [NUM_AGENTS];
  logic [NUM_AGENTS-1:0] col_claim [NUM_RES];
  logic [NUM_AGENTS-1:0] col_hold  [NUM_RES];
  logic [NUM_AGENTS-1:0] col_grant [NUM_RES];
  logic [NUM_AGENTS-1:0] misuse;
  logic [FLAT_W-1:0]     own_flat;

  // claim requests per agent
  always_comb begin
    for (int a = 0; a < NUM_AGENTS; a++) begin
      if (agt_wr_en[a] && agt_wr_op[a] == LOCK_OP_CLAIM)
        claim_row[a] = agt_wr_data[a*NUM_RES +: NUM_RES];
      else
        claim_row[a] = '0;
    end
  end

  // agent-major to resource-major and back
  always_comb begin
    for (int r = 0; r < NUM_RES; r++) begin
      for (int a = 0; a < NUM_AGENTS; a++) begin
        col_claim[r][a] = claim_row[a][r];
        col_hold[r][a]  = own_row[a][r];
      end
    end
  end

  always_comb begin
    for (int a = 0; a < NUM_AGENTS; a++) begin
      for (int r = 0; r < NUM_RES; r++) begin
        grant_row[a][r] = col_grant[r][a];
      end
    end
  end

  always_comb begin
    for (int a = 0; a < NUM_AGENTS; a++) begin
      agt_rd_data[a*NUM_RES +: NUM_RES] = rd_row[a];
      own_flat[a*NUM_RES +: NUM_RES]    = own_row[a];
    end
  end

  generate
    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
      hwlock_arb_col #(.NUM_AGENTS(NUM_AGENTS)) u_arb (
        .req     (col_claim[r]),
        .holders (col_hold[r]),
        .grant   (col_grant[r])
      );
    end
    for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_agent
      hwlock_agent_reg #(.NUM_RES(NUM_RES)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (agt_wr_en[a]),
        .wr_op   (agt_wr_op[a]),
        .wr_data (agt_wr_data[a*NUM_RES +: NUM_RES]),
        .grant   (grant_row[a]),
        .rd_en   (agt_rd_en[a]),
        .own     (own_row[a]),
        .rd_data (rd_row[a]),
        .misuse  (misuse[a])
      );
    end
  endgenerate

  hwlock_err_stat u_err (
    .clk        (clk),
    .rst        (rst),
    .misuse_any (|misuse),
    .clr        (irq_clr),
    .en         (irq_en),
    .sts        (irq_sts),
    .irq        (irq)
  );
endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
  parameter int NUM_AGENTS = 16,
  parameter int NUM_RES    = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_AGENTS-1:0]         agt_wr_en,
  input logic [NUM_AGENTS-1:0]         agt_wr_op,
  input logic [NUM_AGENTS*NUM_RES-1:0] agt_wr_data,
  input logic [NUM_AGENTS*NUM_RES-1:0] own_flat,
  input logic                          irq_en,
  input logic                          irq_clr,
  input logic                          irq_sts,
  input logic                          irq
);
  localparam int FLAT_W = NUM_AGENTS * NUM_RES;

  logic [FLAT_W-1:0] prev_own, prev_set, prev_rel, set_now, rel_now;
  logic              prev_valid;
  logic              multi_owner, bad_rise, bad_fall, prev_misuse;

  always_comb begin
    for (int a = 0; a < NUM_AGENTS; a++) begin
      for (int r = 0; r < NUM_RES; r++) begin
        set_now[a*NUM_RES+r] = agt_wr_en[a] & agt_wr_op[a] & agt_wr_data[a*NUM_RES+r];
        rel_now[a*NUM_RES+r] = agt_wr_en[a] & ~agt_wr_op[a] & agt_wr_data[a*NUM_RES+r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_own   <= '0;
      prev_set   <= '0;
      prev_rel   <= '0;
    end else begin
      prev_valid <= 1'b1;
      prev_own   <= own_flat;
      prev_set   <= set_now;
      prev_rel   <= rel_now;
    end
  end

  always_comb begin
    multi_owner = 1'b0;
    bad_rise    = 1'b0;
    bad_fall    = 1'b0;
    prev_misuse = 1'b0;
    for (int r = 0; r < NUM_RES; r++) begin
      int cnt;
      logic held;
      cnt  = 0;
      held = 1'b0;
      for (int a = 0; a < NUM_AGENTS; a++) begin
        cnt  = cnt + int'(own_flat[a*NUM_RES+r]);
        held = held | prev_own[a*NUM_RES+r];
      end
      if (cnt > 1) multi_owner = 1'b1;
      for (int a = 0; a < NUM_AGENTS; a++) begin
        int i;
        i = a*NUM_RES + r;
        if (own_flat[i] && !prev_own[i] && (!prev_set[i] || held)) bad_rise = 1'b1;
        if (!own_flat[i] && prev_own[i] && !prev_rel[i]) bad_fall = 1'b1;
        if ((prev_set[i] && prev_own[i]) || (prev_rel[i] && !prev_own[i])) prev_misuse = 1'b1;
      end
    end
  end

  // R12
  single_owner_chk: assert property (@(posedge clk) disable iff (rst) !multi_owner);
  // R2 R3
  grant_legal_chk: assert property (@(posedge clk) disable iff (rst) prev_valid |-> !bad_rise);
  // R5 R6
  release_legal_chk: assert property (@(posedge clk) disable iff (rst) prev_valid |-> !bad_fall);
  // R7 R8
  misuse_flag_chk: assert property (@(posedge clk) disable iff (rst) (prev_valid && prev_misuse) |-> irq_sts);
  // R9
  sts_sticky_chk: assert property (@(posedge clk) disable iff (rst) (irq_sts && !irq_clr) |=> irq_sts);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst) !irq_en |=> !irq);
  // R10
  irq_implies_sts_chk: assert property (@(posedge clk) disable iff (rst) irq |-> irq_sts);
endmodule

bind hwlock_bank hwlock_bank_chk #(.NUM_AGENTS(NUM_AGENTS), .NUM_RES(NUM_RES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .agt_wr_en   (agt_wr_en),
  .agt_wr_op   (agt_wr_op),
  .agt_wr_data (agt_wr_data),
  .own_flat    (own_flat),
  .irq_en      (irq_en),
  .irq_clr     (irq_clr),
  .irq_sts     (irq_sts),
  .irq         (irq)
);

// File: tb/hwlock_bank_test.sv
`timescale 1ns/1ps
module hwlock_bank_test;
  localparam int NA = 4;
  localparam int NR = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic [NA-1:0]   wr_en, wr_op, rd_en;
  logic [NA*NR-1:0] wr_data, rd_data;
  logic            irq_en, irq_clr, irq_sts, irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [NR-1:0] m_own [NA];
  logic          m_sts, m_irq;
  logic [31:0]   lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  hwlock_bank #(.NUM_AGENTS(NA), .NUM_RES(NR)) uut (
    .clk(clk), .rst(rst), .agt_wr_en(wr_en), .agt_wr_op(wr_op),
    .agt_wr_data(wr_data), .agt_rd_en(rd_en), .agt_rd_data(rd_data),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_sts(irq_sts), .irq(irq)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = '0; wr_op = '0; wr_data = '0; irq_clr = 1'b0; rd_en = '1;
  endtask

  task automatic wr(int a, logic op, logic [NR-1:0] d);
    wr_en[a] = 1'b1;
    wr_op[a] = op;
    wr_data[a*NR +: NR] = d;
  endtask

  // Inputs are already driven; run one edge against the model.
  task automatic step(string tag);
    logic [NR-1:0] exp_rd [NA];
    logic [NR-1:0] nxt [NA];
    logic err;
    for (int a = 0; a < NA; a++) begin
      exp_rd[a] = m_own[a];
      nxt[a] = m_own[a];
    end
    err = 1'b0;
    for (int r = 0; r < NR; r++) begin
      logic held, taken;
      held = 1'b0;
      taken = 1'b0;
      for (int a = 0; a < NA; a++) held = held | m_own[a][r];
      for (int a = 0; a < NA; a++) begin
        if (wr_en[a] && wr_data[a*NR+r]) begin
          if (wr_op[a]) begin
            if (m_own[a][r]) err = 1'b1;
            else if (!held && !taken) begin
              nxt[a][r] = 1'b1;
              taken = 1'b1;
            end
          end else begin
            if (!m_own[a][r]) err = 1'b1;
            nxt[a][r] = 1'b0;
          end
        end
      end
    end
    m_sts = err | (m_sts & ~irq_clr);
    m_irq = m_sts & irq_en;
    for (int a = 0; a < NA; a++) m_own[a] = nxt[a];
    @(posedge clk);
    @(negedge clk);
    for (int a = 0; a < NA; a++)
      check({"R11/", tag}, $sformatf("agent %0d read", a), 32'(rd_data[a*NR +: NR]), 32'(exp_rd[a]));
    check(tag, "irq_sts", 32'(irq_sts), 32'(m_sts));
    check({"R10/", tag}, "irq", 32'(irq), 32'(m_irq));
    for (int r = 0; r < NR; r++) begin
      int cnt;
      cnt = 0;
      for (int a = 0; a < NA; a++) cnt += int'(rd_data[a*NR+r]);
      n_chk++;
      if (cnt > 1) begin
        n_bad++;
        $display("FAIL R12 resource %0d owners: actual %0d expected <=1", r, cnt);
      end
    end
  endtask

  function automatic logic [31:0] nextr(logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle();
    irq_en = 1'b0;
    rst = 1'b1;
    for (int a = 0; a < NA; a++) m_own[a] = '0;
    m_sts = 1'b0;
    m_irq = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state on the ports
    check("R1", "rd_data", rd_data, '0);
    check("R1", "irq_sts", 32'(irq_sts), 0);
    check("R1", "irq", 32'(irq), 0);
    rst = 1'b0;
    idle(); step("R1");

    idle(); wr(0, 1'b1, 8'h0F); step("R2");           // free claim
    idle(); wr(1, 1'b1, 8'h03); step("R3");           // held by agent 0
    idle(); wr(1, 1'b1, 8'h30); wr(2, 1'b1, 8'h30); wr(3, 1'b1, 8'h30); step("R4");
    idle(); wr(0, 1'b1, 8'h00); wr(1, 1'b0, 8'h00); step("R6");
    idle(); step("R6");
    idle(); wr(0, 1'b1, 8'h01); step("R7");           // re-claim, irq disabled
    idle(); step("R9");
    irq_en = 1'b1;
    idle(); step("R10");
    idle(); irq_clr = 1'b1; step("R9");
    idle(); wr(3, 1'b0, 8'h80); step("R8");           // release unowned
    idle(); irq_clr = 1'b1; step("R9");
    idle(); wr(1, 1'b0, 8'h10); wr(2, 1'b1, 8'h10); step("R3");
    idle(); wr(2, 1'b1, 8'h10); step("R2");
    idle(); wr(0, 1'b0, 8'h05); step("R5");
    idle(); irq_clr = 1'b1; wr(1, 1'b0, 8'h01); step("R9");
    idle(); irq_en = 1'b0; step("R10");

    // Mixed sweep against the model
    for (int i = 0; i < 4000; i++) begin
      idle();
      for (int a = 0; a < NA; a++) begin
        lfsr = nextr(lfsr);
        if (lfsr[1:0] != 2'b00) wr(a, lfsr[2], lfsr[8 +: NR] & lfsr[16 +: NR]);
      end
      lfsr = nextr(lfsr);
      irq_clr = (lfsr[3:0] == 4'h0);
      if (lfsr[9:5] == 5'h0) irq_en = ~irq_en;
      rd_en = lfsr[20 +: NA] | 4'b0001;
      if (rd_en != '1) begin
        rd_en = '1;
      end
      step("R2/R3/R4/R5/R6/R7/R8/R9");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule